// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the raster timing for a cathode-ray display. It counts character clocks horizontally. One clock cycle is one character of eight pixels. It counts scan lines vertically. From a small set of programmed boundaries it derives horizontal and vertical sync, horizontal and vertical blanking, and a display-enable window. It also brings out the live character and line counters and a line-compare match.

Optional features, all programmable:
- Sync polarity for each direction.
- Double scan, in which every logical line is drawn twice.
- Interlace, in which frames alternate between an even and an odd field.

Software writes the timing through a simple write-only register port. The values it writes are held as pending. They are copied into the working set only when the current frame ends, so a mode change never tears a frame.

Top module: `crtc_timing_gen`

## Requirements
- R1: While rstN is low the character and line counters are 0, oddField is 0, lineMatch follows the reset line-compare value, and both sync pins are at their inactive level for the reset polarity.
- R2: charCount steps by one per clock from 0 to hTotal-1, then wraps to 0. hBlank is high while charCount >= hDisp, and so ends at character 0.
- R3: lineCount advances on the cycle where charCount wraps. It counts from 0 up to vTotal+1, because vTotal is stored as the line count minus 2. vBlank is high while lineCount >= vDisp+1, because vDisp is stored as the active lines minus 1.
- R4: displayEn is high exactly when both hBlank and vBlank are low.
- R5: Horizontal sync starts at the character equal to hSyncStart. It stays active up to, and not including, the first later character whose low 5 bits equal hSyncEnd. Bits of hSyncEnd above bit 4 have no effect.
- R6: Vertical sync is evaluated once per line, at character 0 in the even field. It starts on the line equal to vSyncStart. It ends on the first later line whose low 4 bits equal vSyncEnd. Bits of vSyncEnd above bit 3 have no effect.
- R7: Mode register bit 6 set inverts the hSync pin, and bit 7 set inverts the vSync pin. With a bit clear, that sync is active-high.
- R8: Mode register bit 0 enables double scan: lineCount advances only on every second character wrap, so each line is output twice.
- R9: Mode register bit 1 enables interlace:
  - the active region per field is (vDisp+1)/2 lines, rounded down, while every other vertical value is used as written;
  - oddField toggles at each frame end;
  - in the odd field, vertical sync is evaluated at character hTotal/2 (rounded down) instead of at character 0.
- R10: lineMatch is high whenever lineCount equals lineCmp. lineCmp resets to 0x3FF.
- R11: A write is taken when cfgWe is high. The address selects the register: 0 hTotal, 1 hDisp, 2 hSyncStart, 3 hSyncEnd, 4 vTotal, 5 vDisp, 6 vSyncStart, 7 vSyncEnd, 8 lineCmp, 9 mode. A written value first affects the outputs on the cycle after the clock edge on which the last character of the last line ends. The only exception is a write on that same edge, which waits one more frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register select |
| cfgData | input | 11 | Register write value |
| hSync | output | 1 | Horizontal sync pin, polarity applied |
| vSync | output | 1 | Vertical sync pin, polarity applied |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| displayEn | output | 1 | Active picture window |
| charCount | output | 8 | Character position in the line |
| lineCount | output | 11 | Line position in the frame or field |
| lineMatch | output | 1 | Line counter equals line-compare value |
| oddField | output | 1 | Odd interlace field in progress |

## Verification
The assertions check the following on every cycle:
- the character counter only steps by one or returns to zero;
- the line counter moves only where a line begins;
- vertical blanking, the line-compare match and the field flag stay constant inside a line;
- vertical sync moves only at character 0 in the even field.

Only the bench scenarios can show:
- the exact positions of the sync edges;
- that the upper sync-end bits are ignored;
- the polarity inversion;
- the line repetition under double scan;
- the halved active region and half-line sync delay under interlace;
- that register writes wait for the frame boundary.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int CRTC_HW = 8;   // character counter width
  parameter int CRTC_VW = 11;  // line counter width
  parameter int HSE_BITS = 5;  // compared bits of horizontal sync end
  parameter int VSE_BITS = 4;  // compared bits of vertical sync end

  localparam logic [3:0] ADDR_HTOTAL = 4'd0;
  localparam logic [3:0] ADDR_HDISP  = 4'd1;
  localparam logic [3:0] ADDR_HSS    = 4'd2;
  localparam logic [3:0] ADDR_HSE    = 4'd3;
  localparam logic [3:0] ADDR_VTOTAL = 4'd4;
  localparam logic [3:0] ADDR_VDISP  = 4'd5;
  localparam logic [3:0] ADDR_VSS    = 4'd6;
  localparam logic [3:0] ADDR_VSE    = 4'd7;
  localparam logic [3:0] ADDR_LCMP   = 4'd8;
  localparam logic [3:0] ADDR_MODE   = 4'd9;

  // working timing set seen by the datapath
  typedef struct packed {
    logic [CRTC_HW-1:0]  hTotal;
    logic [CRTC_HW-1:0]  hDisp;
    logic [CRTC_HW-1:0]  hSyncStart;
    logic [HSE_BITS-1:0] hSyncEnd;
    logic [CRTC_VW-1:0]  vTotal;
    logic [CRTC_VW-1:0]  vDisp;
    logic [CRTC_VW-1:0]  vSyncStart;
    logic [VSE_BITS-1:0] vSyncEnd;
    logic [CRTC_VW-1:0]  lineCmp;
    logic                interlace;
    logic                hNeg;
    logic                vNeg;
  } crtc_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lineStep;
    logic oddField;
  } crtc_strobe_t;
endpackage

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter crtc_cfg_t RST_CFG = '0,
  parameter bit        RST_DBL = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [3:0]         cfgAddr,
  input  logic [CRTC_VW-1:0] cfgData,
  input  logic               charWrap,
  input  logic               lastLine,
  output crtc_cfg_t          cfgCur,
  output crtc_strobe_t       strb
);
  crtc_cfg_t cfgPend;
  logic      dblPend, dblCur;
  logic      scanPhase, oddQ;
  logic      lineStep, frameEnd;

  assign lineStep = charWrap & (~dblCur | scanPhase);
  assign frameEnd = lineStep & lastLine;

  assign strb.lineStep = lineStep;
  assign strb.oddField = oddQ;

  // host-visible pending set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPend <= RST_CFG;
      dblPend <= RST_DBL;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_HTOTAL: cfgPend.hTotal     <= cfgData[CRTC_HW-1:0];
        ADDR_HDISP:  cfgPend.hDisp      <= cfgData[CRTC_HW-1:0];
        ADDR_HSS:    cfgPend.hSyncStart <= cfgData[CRTC_HW-1:0];
        ADDR_HSE:    cfgPend.hSyncEnd   <= cfgData[HSE_BITS-1:0];
        ADDR_VTOTAL: cfgPend.vTotal     <= cfgData;
        ADDR_VDISP:  cfgPend.vDisp      <= cfgData;
        ADDR_VSS:    cfgPend.vSyncStart <= cfgData;
        ADDR_VSE:    cfgPend.vSyncEnd   <= cfgData[VSE_BITS-1:0];
        ADDR_LCMP:   cfgPend.lineCmp    <= cfgData;
        ADDR_MODE: begin
          dblPend           <= cfgData[0];
          cfgPend.interlace <= cfgData[1];
          cfgPend.hNeg      <= cfgData[6];
          cfgPend.vNeg      <= cfgData[7];
        end
        default: ;
      endcase
    end
  end

  // working set, scan repeat phase and field flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCur    <= RST_CFG;
      dblCur    <= RST_DBL;
      scanPhase <= 1'b0;
      oddQ      <= 1'b0;
    end else begin
      if (charWrap) scanPhase <= dblCur & ~scanPhase;
      if (frameEnd) begin
        cfgCur    <= cfgPend;
        dblCur    <= dblPend;
        scanPhase <= 1'b0;
        oddQ      <= cfgCur.interlace & ~oddQ;
      end
    end
  end
endmodule

// File: rtl/crtc_datapath.sv
module crtc_datapath
  import crtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  crtc_cfg_t          cfg,
  input  crtc_strobe_t       strb,
  output logic               charWrap,
  output logic               lastLine,
  output logic               hSync,
  output logic               vSync,
  output logic               hBlank,
  output logic               vBlank,
  output logic               displayEn,
  output logic [CRTC_HW-1:0] charCount,
  output logic [CRTC_VW-1:0] lineCount,
  output logic               lineMatch,
  output logic               oddField
);
  logic [CRTC_HW-1:0] hCnt;
  logic [CRTC_VW-1:0] vCnt;
  logic               hOn, vOn, hRaw, vRaw, vEvt;
  logic [CRTC_VW:0]   vActLines;

  assign charWrap = (hCnt == cfg.hTotal - 1'b1);
  assign lastLine = (vCnt == cfg.vTotal + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
      hOn  <= 1'b0;
      vOn  <= 1'b0;
    end else begin
      hCnt <= charWrap ? '0 : hCnt + 1'b1;
      if (strb.lineStep) vCnt <= lastLine ? '0 : vCnt + 1'b1;
      hOn <= hRaw;
      vOn <= vRaw;
    end
  end

  // sync windows: start on full compare, end on low-bit compare
  always_comb begin
    hRaw = (hCnt == cfg.hSyncStart) |
           (hOn & (hCnt[HSE_BITS-1:0] != cfg.hSyncEnd));
    vEvt = strb.oddField ? (hCnt == (cfg.hTotal >> 1)) : (hCnt == '0);
    if (vEvt)
      vRaw = (vCnt == cfg.vSyncStart) |
             (vOn & (vCnt[VSE_BITS-1:0] != cfg.vSyncEnd));
    else
      vRaw = vOn;
  end

  always_comb begin
    if (cfg.interlace) vActLines = ({1'b0, cfg.vDisp} + 1'b1) >> 1;
    else               vActLines = {1'b0, cfg.vDisp} + 1'b1;
  end

  assign hBlank    = (hCnt >= cfg.hDisp);
  assign vBlank    = ({1'b0, vCnt} >= vActLines);
  assign displayEn = ~hBlank & ~vBlank;
  assign hSync     = hRaw ^ cfg.hNeg;
  assign vSync     = vRaw ^ cfg.vNeg;
  assign charCount = hCnt;
  assign lineCount = vCnt;
  assign lineMatch = (vCnt == cfg.lineCmp);
  assign oddField  = strb.oddField;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int H_TOTAL_RST = 100,
  parameter int H_DISP_RST  = 80,
  parameter int H_SS_RST    = 82,
  parameter int H_SE_RST    = 94,
  parameter int V_TOTAL_RST = 523,
  parameter int V_DISP_RST  = 479,
  parameter int V_SS_RST    = 490,
  parameter int V_SE_RST    = 492,
  parameter int LCMP_RST    = 'h3FF,
  parameter int MODE_RST    = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [3:0]         cfgAddr,
  input  logic [CRTC_VW-1:0] cfgData,
  output logic               hSync,
  output logic               vSync,
  output logic               hBlank,
  output logic               vBlank,
  output logic               displayEn,
  output logic [CRTC_HW-1:0] charCount,
  output logic [CRTC_VW-1:0] lineCount,
  output logic               lineMatch,
  output logic               oddField
);
  localparam logic [7:0] MODE_BITS = 8'(MODE_RST);
  localparam crtc_cfg_t RST_CFG = '{
    hTotal:     CRTC_HW'(H_TOTAL_RST),
    hDisp:      CRTC_HW'(H_DISP_RST),
    hSyncStart: CRTC_HW'(H_SS_RST),
    hSyncEnd:   HSE_BITS'(H_SE_RST),
    vTotal:     CRTC_VW'(V_TOTAL_RST),
    vDisp:      CRTC_VW'(V_DISP_RST),
    vSyncStart: CRTC_VW'(V_SS_RST),
    vSyncEnd:   VSE_BITS'(V_SE_RST),
    lineCmp:    CRTC_VW'(LCMP_RST),
    interlace:  MODE_BITS[1],
    hNeg:       MODE_BITS[6],
    vNeg:       MODE_BITS[7]
  };

  crtc_cfg_t    cfgCur;
  crtc_strobe_t strb;
  logic         charWrap, lastLine;

  crtc_ctrl #(.RST_CFG(RST_CFG), .RST_DBL(MODE_BITS[0])) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .charWrap(charWrap), .lastLine(lastLine),
    .cfgCur(cfgCur), .strb(strb)
  );

  crtc_datapath dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfgCur), .strb(strb),
    .charWrap(charWrap), .lastLine(lastLine),
    .hSync(hSync), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
    .displayEn(displayEn), .charCount(charCount), .lineCount(lineCount),
    .lineMatch(lineMatch), .oddField(oddField)
  );
endmodule

// File: rtl/crtc_timing_gen_chk.sv
module crtc_timing_gen_chk #(
  parameter int HW = 8,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          vSync,
  input logic          hBlank,
  input logic          vBlank,
  input logic [HW-1:0] charCount,
  input logic [VW-1:0] lineCount,
  input logic          lineMatch,
  input logic          oddField
);
  AST_CHAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (charCount != '0) |-> (charCount == $past(charCount) + 1'b1)); // R2
  AST_HBLANK_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hBlank) |-> (charCount == '0)); // R2
  AST_LINE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount != $past(lineCount)) |-> (charCount == '0)); // R3
  AST_VBLANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (charCount != '0) |-> $stable(vBlank)); // R3
  AST_VSYNC_EVEN_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!oddField && charCount != '0) |-> $stable(vSync)); // R6
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (charCount != '0) |-> $stable(oddField)); // R9
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (charCount != '0) |-> (lineMatch == $past(lineMatch))); // R10
endmodule

bind crtc_timing_gen crtc_timing_gen_chk #(.HW(crtc_pkg::CRTC_HW), .VW(crtc_pkg::CRTC_VW)) chk_i (
  .clk(clk), .rstN(rstN), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
  .charCount(charCount), .lineCount(lineCount), .lineMatch(lineMatch),
  .oddField(oddField)
);

// File: tb/crtc_timing_gen_tb_top.sv
`timescale 1ns/1ps
module crtc_timing_gen_tb_top;
  import crtc_pkg::*;

  localparam int TB_HT = 20, TB_HD = 12, TB_HSS = 14, TB_HSE = 17;
  localparam int TB_VT = 8, TB_VD = 5, TB_VSS = 7, TB_VSE = 9;
  localparam int TB_LC = 'h3FF, TB_MODE = 0;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rstN = 1'b0;
  logic               cfgWe = 1'b0;
  logic [3:0]         cfgAddr = '0;
  logic [CRTC_VW-1:0] cfgData = '0;
  logic               hSync, vSync, hBlank, vBlank, displayEn, lineMatch, oddField;
  logic [CRTC_HW-1:0] charCount;
  logic [CRTC_VW-1:0] lineCount;

  crtc_timing_gen #(
    .H_TOTAL_RST(TB_HT), .H_DISP_RST(TB_HD), .H_SS_RST(TB_HSS), .H_SE_RST(TB_HSE),
    .V_TOTAL_RST(TB_VT), .V_DISP_RST(TB_VD), .V_SS_RST(TB_VSS), .V_SE_RST(TB_VSE),
    .LCMP_RST(TB_LC), .MODE_RST(TB_MODE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hSync(hSync), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
    .displayEn(displayEn), .charCount(charCount), .lineCount(lineCount),
    .lineMatch(lineMatch), .oddField(oddField)
  );

  typedef struct {
    bit hs, vs, hb, vb, de, lm, odd;
    int cc, lc;
  } exp_t;

  exp_t expQ[$];
  int   vectors = 0, miscompares = 0;
  bit   finished = 0;
  string phaseTag = "R1 reset";

  // reference state derived from the requirements
  crtc_cfg_t mCur, mPend;
  bit mDblCur, mDblPend, scan, field, hOn, vOn;
  int hc, vc;

  function automatic crtc_cfg_t resetCfg();
    crtc_cfg_t c;
    c.hTotal = CRTC_HW'(TB_HT); c.hDisp = CRTC_HW'(TB_HD);
    c.hSyncStart = CRTC_HW'(TB_HSS); c.hSyncEnd = HSE_BITS'(TB_HSE);
    c.vTotal = CRTC_VW'(TB_VT); c.vDisp = CRTC_VW'(TB_VD);
    c.vSyncStart = CRTC_VW'(TB_VSS); c.vSyncEnd = VSE_BITS'(TB_VSE);
    c.lineCmp = CRTC_VW'(TB_LC);
    c.interlace = 1'b0; c.hNeg = 1'b0; c.vNeg = 1'b0;
    return c;
  endfunction

  function automatic bit hRawNow();
    return (hc == int'(mCur.hSyncStart)) ||
           (hOn && (hc % 32) != int'(mCur.hSyncEnd));
  endfunction

  function automatic bit vRawNow();
    bit evt;
    evt = field ? (hc == int'(mCur.hTotal) / 2) : (hc == 0);
    if (!evt) return vOn;
    return (vc == int'(mCur.vSyncStart)) ||
           (vOn && (vc % 16) != int'(mCur.vSyncEnd));
  endfunction

  function automatic exp_t expNow();
    exp_t e;
    int act;
    act = mCur.interlace ? (int'(mCur.vDisp) + 1) / 2 : int'(mCur.vDisp) + 1;
    e.hb  = hc >= int'(mCur.hDisp);
    e.vb  = vc >= act;
    e.de  = !e.hb && !e.vb;
    e.hs  = hRawNow() ^ mCur.hNeg;
    e.vs  = vRawNow() ^ mCur.vNeg;
    e.cc  = hc;
    e.lc  = vc;
    e.lm  = (vc == int'(mCur.lineCmp));
    e.odd = field;
    return e;
  endfunction

  // driver side: advance the model on every edge and push the expectation
  always @(posedge clk) begin
    if (!rstN) begin
      mCur = resetCfg(); mPend = resetCfg();
      mDblCur = 0; mDblPend = 0; scan = 0; field = 0;
      hOn = 0; vOn = 0; hc = 0; vc = 0;
    end else begin
      bit nh, nv, cw, ls, last, fe;
      nh = hRawNow(); nv = vRawNow();
      cw = (hc == int'(mCur.hTotal) - 1);
      ls = cw && (!mDblCur || scan);
      last = (vc == int'(mCur.vTotal) + 1);
      fe = ls && last;
      hOn = nh; vOn = nv;
      if (cw) scan = mDblCur ? !scan : 1'b0;
      hc = cw ? 0 : hc + 1;
      if (ls) vc = last ? 0 : vc + 1;
      if (fe) begin
        field = mCur.interlace ? !field : 1'b0;
        mCur = mPend; mDblCur = mDblPend; scan = 0;
      end
      if (cfgWe) begin
        case (cfgAddr)
          4'd0: mPend.hTotal = cfgData[CRTC_HW-1:0];
          4'd1: mPend.hDisp = cfgData[CRTC_HW-1:0];
          4'd2: mPend.hSyncStart = cfgData[CRTC_HW-1:0];
          4'd3: mPend.hSyncEnd = cfgData[4:0];
          4'd4: mPend.vTotal = cfgData;
          4'd5: mPend.vDisp = cfgData;
          4'd6: mPend.vSyncStart = cfgData;
          4'd7: mPend.vSyncEnd = cfgData[3:0];
          4'd8: mPend.lineCmp = cfgData;
          4'd9: begin
            mDblPend = cfgData[0]; mPend.interlace = cfgData[1];
            mPend.hNeg = cfgData[6]; mPend.vNeg = cfgData[7];
          end
          default: ;
        endcase
      end
    end
    expQ.push_back(expNow());
  end

  task automatic fieldCmp(input string req, input string name, input int act,
                          input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t",
               req, phaseTag, name, act, exp, $time);
      bad = 1;
    end
  endtask

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    if (!finished && expQ.size() > 0) begin
      exp_t e;
      bit bad;
      e = expQ.pop_front();
      bad = 0;
      fieldCmp("R2", "charCount", int'(charCount), e.cc, bad);
      fieldCmp("R2", "hBlank", int'(hBlank), int'(e.hb), bad);
      fieldCmp("R3", "lineCount", int'(lineCount), e.lc, bad);
      fieldCmp("R3", "vBlank", int'(vBlank), int'(e.vb), bad);
      fieldCmp("R4", "displayEn", int'(displayEn), int'(e.de), bad);
      fieldCmp("R5", "hSync", int'(hSync), int'(e.hs), bad);
      fieldCmp("R6", "vSync", int'(vSync), int'(e.vs), bad);
      fieldCmp("R10", "lineMatch", int'(lineMatch), int'(e.lm), bad);
      fieldCmp("R9", "oddField", int'(oddField), int'(e.odd), bad);
      vectors++;
      if (bad) miscompares++;
    end
  end

  task automatic cfgWrite(input logic [3:0] a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = CRTC_VW'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    runCycles(4);                 // R1 reset outputs compared while rstN low
    rstN = 1'b1;
    phaseTag = "R2 R3 R4 base mode";
    runCycles(2 * 200 + 7);
    // R11: mid-frame writes must wait for the frame end
    phaseTag = "R11 R7 R5 R6 R10 reload, polarity, low-bit ends";
    cfgWrite(4'd8, 3);            // lineCmp
    cfgWrite(4'd9, 'hC0);         // invert both sync pins
    cfgWrite(4'd3, 49);           // only low 5 bits (17) matter
    cfgWrite(4'd7, 25);           // only low 4 bits (9) matter
    runCycles(2 * 200 + 30);
    phaseTag = "R8 double scan";
    cfgWrite(4'd9, 'h01);
    runCycles(3 * 400 + 200);
    phaseTag = "R9 interlace";
    cfgWrite(4'd5, 11);
    cfgWrite(4'd8, 4);
    cfgWrite(4'd9, 'h02);
    runCycles(5 * 200 + 50);
    phaseTag = "R9 R7 interlace inverted";
    cfgWrite(4'd9, 'h82);
    runCycles(3 * 200);
    endRun();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=running expected=done");
      miscompares++;
      endRun();
    end
  end
endmodule